// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block sits in front of a single-ported synchronous SRAM array built from two 9-bit byte lanes. Every rising clock edge it classifies the cycle as idle, deselect, read, write or suspend. The inputs are three chip selects of mixed polarity, two address strobes, a burst-advance input and a three-level write decode (global write, byte-write gate, per-lane enables). From that class it issues registered array write strobes per lane and a registered load pulse for the read-data output register. It also decides when the shared data bus may be driven.

Reads are pipelined: the load pulse follows the accepting edge, and the data sits in the output register one cycle later. The bus drive is gated at once by an asynchronous output enable and an asynchronous sleep input. Deselecting releases the bus after one further edge. Sleep clears all activity and keeps the array contents. For a set number of edges after sleep ends, writes are dropped and reads are still served. The bench supplies the array, the address and data input registers, and the output register.

Top module: `psram_cycle_ctrl`

## Requirements
- R1: With `gw_n` low on an accepted write-class cycle, `arr_we` is 2'b11 after that edge, whatever `bw_n` and `lane_n` are.
- R2: With `gw_n` high and `bw_n` low, `arr_we[i]` after the edge equals the inverse of `lane_n[i]` (bit 0 is the low lane, data bits 8:0; bit 1 is data bits 17:9).
- R3: A cycle is a write when at least one lane strobe would be set; when `bw_n` is high with `gw_n` high, or all `lane_n` bits are high, it is a read and pulses `rd_load` instead.
- R4: A new access starts when `strb_ctrl_n` is low, or when `strb_proc_n` and `ce_main_n` are both low. The processor strobe is ignored while `ce_main_n` is high. A start with `ce_main_n`=0, `ce_lo_n`=0 and `ce_hi`=1 selects; any other start deselects and makes no access.
- R5: With no start while selected, `adv_n` low repeats the current decode (burst step) and `adv_n` high suspends, giving no access while the output register holds. With no start while deselected, no access happens even if `adv_n` is low.
- R6: `arr_we` and `rd_load` are valid for exactly the cycle after the accepting edge. Read data is valid, and may be driven, from the edge after the `rd_load` pulse.
- R7: `bus_drive` is high only while `oe_n` is low, `sleep` is low and the output register holds read data. `oe_n` and `sleep` act without waiting for a clock.
- R8: After a deselect edge, `bus_drive` stays high at most until the next edge and is low from then on.
- R9: While `sleep` is high, every other input is ignored: `arr_we` and `rd_load` stay zero, `bus_drive` is low, and the device is left deselected.
- R10: For the first RECOVER_CYCLES edges after `sleep` falls, write cycles are dropped (`arr_we` stays zero). Read cycles are accepted. Writes work again on the next edge.
- R11: While `rst_n` is low, `arr_we`, `rd_load` and `bus_drive` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| ce_main_n | input | 1 | Master chip select, active low, also gates the processor strobe |
| ce_lo_n | input | 1 | Secondary chip select, active low |
| ce_hi | input | 1 | Secondary chip select, active high |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte-write gate, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| arr_we | output | LANES | Registered array write strobes per lane |
| rd_load | output | 1 | Registered load pulse for the read-data register |
| bus_drive | output | 1 | Data-bus drive enable |

## Verification
A vector table walks strobe-started reads and writes through burst steps and suspends. It runs global writes, single-lane and two-lane writes, and writes with all lanes off or the byte gate off, which separates the three decode levels from one another. Starts with each chip select in turn inactive, and a processor strobe with the master select high, separate selection from deselection and blocking. Bus-drive samples taken one and two edges after a read, and after a deselect, tell the pipeline delay and the single-cycle release apart. Directed runs check merged lane data read back from a model array, and a sleep window followed by its write-blocking recovery, in which a read still goes through.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_DESEL,
        OP_READ,
        OP_WRITE,
        OP_SUSPEND
    } cyc_op_e;

endpackage

// File: rtl/psram_start_decode.sv
module psram_start_decode (
    input  logic ce_main_n,
    input  logic ce_lo_n,
    input  logic ce_hi,
    input  logic strb_proc_n,
    input  logic strb_ctrl_n,
    output logic start,
    output logic selected
);
    logic proc_start;

    always_comb begin
        // processor strobe counts only while the master select is active
        proc_start = ~strb_proc_n & ~ce_main_n;
        start      = proc_start | ~strb_ctrl_n;
        selected   = ~ce_main_n & ~ce_lo_n & ce_hi;
    end
endmodule

// File: rtl/psram_write_decode.sv
module psram_write_decode #(
    parameter int LANES = 2
) (
    input  logic             gw_n,
    input  logic             bw_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_mask,
    output logic             is_write
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // global write overrides; otherwise the byte gate passes lane enables
        assign lane_mask[i] = ~gw_n | (~bw_n & ~lane_n[i]);
    end

    assign is_write = |lane_mask;
endmodule

// File: rtl/psram_cycle_ctrl.sv
module psram_cycle_ctrl #(
    parameter int LANES          = 2,
    parameter int RECOVER_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_main_n,
    input  logic             ce_lo_n,
    input  logic             ce_hi,
    input  logic             strb_proc_n,
    input  logic             strb_ctrl_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bw_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             oe_n,
    input  logic             sleep,
    output logic [LANES-1:0] arr_we,
    output logic             rd_load,
    output logic             bus_drive
);
    import psram_pkg::*;

    localparam int RW = (RECOVER_CYCLES > 0) ? $clog2(RECOVER_CYCLES + 1) : 1;
    localparam logic [RW-1:0] REC_LOAD = RW'(RECOVER_CYCLES);

    typedef struct packed {
        logic             active;
        logic [LANES-1:0] we;
        logic             ld;
        logic             keep;
        logic             rd_mode;
        logic [RW-1:0]    rec;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    cyc_op_e     op;
    logic        start, selected, is_write, blocked, rec_idle;
    logic [LANES-1:0] lane_mask;

    psram_start_decode u_start (
        .ce_main_n  (ce_main_n),
        .ce_lo_n    (ce_lo_n),
        .ce_hi      (ce_hi),
        .strb_proc_n(strb_proc_n),
        .strb_ctrl_n(strb_ctrl_n),
        .start      (start),
        .selected   (selected)
    );

    psram_write_decode #(.LANES(LANES)) u_wdec (
        .gw_n     (gw_n),
        .bw_n     (bw_n),
        .lane_n   (lane_n),
        .lane_mask(lane_mask),
        .is_write (is_write)
    );

    assign blocked  = (st_q.rec != '0);
    assign rec_idle = ~blocked;

    always_comb begin
        st_d      = st_q;
        st_d.we   = '0;
        st_d.ld   = 1'b0;
        st_d.keep = 1'b0;
        op        = OP_IDLE;

        if (sleep) begin
            st_d.active = 1'b0;
            st_d.rec    = REC_LOAD;
        end else begin
            if (blocked) begin
                st_d.rec = st_q.rec - 1'b1;
            end
            if (start) begin
                st_d.active = selected;
                if (!selected) begin
                    op = OP_DESEL;
                end else if (is_write) begin
                    op = blocked ? OP_SUSPEND : OP_WRITE;
                end else begin
                    op = OP_READ;
                end
            end else if (st_q.active) begin
                if (!adv_n) begin
                    if (is_write) begin
                        op = blocked ? OP_SUSPEND : OP_WRITE;
                    end else begin
                        op = OP_READ;
                    end
                end else begin
                    op = OP_SUSPEND;
                end
            end
        end

        case (op)
            OP_WRITE:   st_d.we   = lane_mask;
            OP_READ:    st_d.ld   = 1'b1;
            OP_SUSPEND: st_d.keep = 1'b1;
            default:    ;
        endcase

        // output register holds read data one edge after its load pulse
        st_d.rd_mode = ~sleep & (st_q.ld | (st_q.keep & st_q.rd_mode));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arr_we    = st_q.we;
    assign rd_load   = st_q.ld;
    assign bus_drive = st_q.rd_mode & ~oe_n & ~sleep;

endmodule

module psram_cycle_ctrl_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep,
    input logic             oe_n,
    input logic             gw_n,
    input logic             strb_ctrl_n,
    input logic             ce_main_n,
    input logic             ce_lo_n,
    input logic             ce_hi,
    input logic [LANES-1:0] arr_we,
    input logic             rd_load,
    input logic             bus_drive,
    input logic             rec_idle
);
    // R1
    global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && rec_idle && !strb_ctrl_n && !ce_main_n && !ce_lo_n && ce_hi && !gw_n)
        |=> (arr_we == {LANES{1'b1}}));

    // R3
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |-> (arr_we == '0));

    // R4
    desel_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strb_ctrl_n && !ce_hi) |=> (arr_we == '0 && !rd_load));

    // R6
    read_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> (bus_drive || oe_n || sleep));

    // R7
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || sleep) |-> !bus_drive);

    // R8
    desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strb_ctrl_n && !ce_hi) |=> ##1 !bus_drive);

    // R9
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (arr_we == '0 && !rd_load));

    // R10
    recover_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !rec_idle) |=> (arr_we == '0));
endmodule

bind psram_cycle_ctrl psram_cycle_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .oe_n       (oe_n),
    .gw_n       (gw_n),
    .strb_ctrl_n(strb_ctrl_n),
    .ce_main_n  (ce_main_n),
    .ce_lo_n    (ce_lo_n),
    .ce_hi      (ce_hi),
    .arr_we     (arr_we),
    .rd_load    (rd_load),
    .bus_drive  (bus_drive),
    .rec_idle   (rec_idle)
);

// File: tb/psram_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module psram_cycle_ctrl_bench;
    localparam int NV = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_main_n, ce_lo_n, ce_hi, strb_proc_n, strb_ctrl_n, adv_n;
    logic gw_n, bw_n, oe_n, sleep;
    logic [1:0] lane_n;
    logic [1:0] arr_we;
    logic rd_load, bus_drive;

    logic [1:0]  addr, addr_q;
    logic [17:0] din, din_q, dout_q;
    logic [17:0] mem [4];

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    psram_cycle_ctrl u_psram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_main_n(ce_main_n), .ce_lo_n(ce_lo_n),
        .ce_hi(ce_hi), .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
        .adv_n(adv_n), .gw_n(gw_n), .bw_n(bw_n), .lane_n(lane_n), .oe_n(oe_n),
        .sleep(sleep), .arr_we(arr_we), .rd_load(rd_load), .bus_drive(bus_drive)
    );

    // array, input registers and output register
    always @(posedge clk) begin
        if (arr_we[0]) mem[addr_q][8:0]  <= din_q[8:0];
        if (arr_we[1]) mem[addr_q][17:9] <= din_q[17:9];
        if (rd_load)   dout_q <= mem[addr_q];
        addr_q <= addr;
        din_q  <= din;
    end

    // {cm,cl,ch}_{sp,sc,adv}_{gw,bw,ln1,ln0}_{oe}_{we1,we0,ld,drv}
    localparam logic [14:0] VEC [NV] = '{
        15'b101_111_1111_0_0000, // 0 idle R5
        15'b001_101_1111_0_0010, // 1 strobe read R3
        15'b101_110_1111_0_0011, // 2 burst read R5 R6
        15'b101_111_1111_0_0001, // 3 suspend R5
        15'b101_111_1111_0_0001, // 4 suspend R5
        15'b000_101_1111_0_0001, // 5 deselect by ce_hi R4 R8
        15'b101_111_1111_0_0000, // 6 released R8
        15'b001_011_0111_0_1100, // 7 proc strobe global write R1
        15'b101_110_1010_0_0100, // 8 low lane R2
        15'b101_110_1001_0_1000, // 9 high lane R2
        15'b101_110_1011_0_0010, // 10 no lane -> read R3
        15'b101_110_1100_0_0011, // 11 bw high -> read R3
        15'b101_111_1111_1_0000, // 12 oe high R7
        15'b101_011_1111_0_0001, // 13 proc strobe blocked R4
        15'b101_111_1111_0_0001, // 14 still selected R4
        15'b011_101_1111_0_0001, // 15 deselect by ce_lo R4
        15'b101_111_1111_0_0000, // 16 released R8
        15'b101_110_0111_0_0000, // 17 advance while deselected R5
        15'b001_101_1000_0_1100, // 18 two-lane byte write R2
        15'b101_111_1111_0_0000  // 19 suspend after write R6
    };

    function automatic string vtag(int i);
        case (i)
            7:               return "R1";
            8, 9, 18:        return "R2";
            1, 10, 11:       return "R3";
            13, 14, 15:      return "R4";
            0, 3, 4, 17:     return "R5";
            2, 19:           return "R6";
            12:              return "R7";
            default:         return "R8";
        endcase
    endfunction

    task automatic apply(input logic [10:0] v);
        {ce_main_n, ce_lo_n, ce_hi, strb_proc_n, strb_ctrl_n, adv_n,
         gw_n, bw_n, lane_n, oe_n} = v;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    localparam logic [10:0] IDLE_IN  = 11'b101_111_1111_0;
    localparam logic [10:0] RD_START = 11'b001_101_1111_0;
    localparam logic [10:0] GW_START = 11'b001_101_0111_0;
    localparam logic [10:0] HI_LANE  = 11'b001_101_1001_0;

    initial begin
        apply(IDLE_IN);
        sleep = 1'b0;
        addr  = 2'd0;
        din   = '0;
        for (int i = 0; i < 4; i++) mem[i] = '0;
        dout_q = '0;
        // R11 reset state, with a read start presented
        apply(RD_START);
        repeat (3) @(negedge clk);
        check("R11", {15'd0, arr_we, rd_load}, 18'd0);
        check("R11", {17'd0, bus_drive}, 18'd0);
        apply(IDLE_IN);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][14:4]);
            tick();
            check(vtag(i), {14'd0, arr_we, rd_load, bus_drive}, {14'd0, VEC[i][3:0]});
        end

        // R2 lane merge through the model array
        addr = 2'd1; din = 18'h2A5A5;
        apply(GW_START); tick();
        apply(IDLE_IN);  tick();
        din = 18'h3FFFF;
        apply(HI_LANE);  tick();
        apply(IDLE_IN);  tick();
        apply(RD_START); tick();
        apply(IDLE_IN);  tick();
        check("R2", dout_q, 18'h3FFA5);
        check("R6", {17'd0, bus_drive}, 18'd1);

        // R7 / R9 sleep gates the bus without a clock
        sleep = 1'b1;
        #0.5;
        check("R7", {17'd0, bus_drive}, 18'd0);
        apply(GW_START); tick();
        check("R9", {15'd0, arr_we, rd_load}, 18'd0);
        tick();
        check("R9", {15'd0, arr_we, rd_load}, 18'd0);

        // R10 recovery: 3 edges drop writes, reads still accepted
        sleep = 1'b0;
        tick();
        check("R10", {15'd0, arr_we, rd_load}, 18'd0);
        apply(RD_START); tick();
        check("R10", {15'd0, arr_we, rd_load}, 18'd1);
        apply(GW_START); tick();
        check("R10", {15'd0, arr_we, rd_load}, 18'd0);
        tick();
        check("R10", {15'd0, arr_we, rd_load}, 18'b110);
        apply(IDLE_IN); tick();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule